// File: doc/BRIEF.md
# Quasi-Bidirectional Port Pull-Up Control

This block is the digital side of an 8-bit port whose pins serve as inputs and outputs without any direction register. Each bit holds an output latch and drives four pad enables: a strong pull-down, a weak pull-up, a medium pull-up and a short strong pull-up pulse. A latch bit at 0 pulls its pin hard to ground. A latch bit at 1 leaves the pin pulled high only weakly, so an external device can still drive it low. Software makes a pin an input simply by writing 1 to its bit.

The medium pull-up supplies most of the high-level current. It stays on only while the pin is seen high, so it lets go once an outside device pulls the pin low. When a bit goes from 0 to 1, a strong pull-up pulse lasting two clocks speeds up the rising edge. One global input turns off the weak pull-up on every bit to save power. A read returns either the latch, for read-modify-write sequences, or the pin levels after a two-flop synchroniser.

Top module: `qb_port_ctrl`

## Requirements
- R1: A write (`wr_en`=1) loads `wr_data` into the latch at the clock edge. From the next cycle, `pd_en[i]` is 1 exactly when latch bit i is 0.
- R2: `weak_en[i]` is 1 when latch bit i is 1 and `weak_off` is 0.
- R3: While `weak_off` is 1, every bit of `weak_en` is 0, whatever the latch holds.
- R4: `med_en[i]` is 1 only when latch bit i is 1 and the synchronised pin bit i is 1. The pin passes two flops, so a change on `pin_in` reaches `med_en` after the second clock edge.
- R5: A write that takes latch bit i from 0 to 1 sets `strong_en[i]` in the two cycles after that write edge, and clears it after them. Writing 1 over a 1 starts no pulse.
- R6: Writing 0 to a bit ends its pulse at once. A later 0-to-1 write starts a new full two-cycle pulse.
- R7: Reset (`rst_n`=0) sets every latch bit to 1 and every synchroniser flop to 1. No strong pulse follows reset: `strong_en`=0 and `pd_en`=0 after reset.
- R8: With `rd_rmw`=1, `rd_data` is the latch. With `rd_rmw`=0, it is the synchronised pin value, two edges behind `pin_in`.
- R9: All bits act independently. A pulse, pull-down or medium enable on one bit does not depend on any other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Latch write strobe |
| wr_data | input | 8 | Value to load into the latch |
| rd_rmw | input | 1 | 1 selects the latch for `rd_data`, 0 selects the pins |
| rd_data | output | 8 | Read value |
| weak_off | input | 1 | Global disable of the weak pull-ups |
| pin_in | input | 8 | Pad input levels, asynchronous |
| pd_en | output | 8 | Strong pull-down enables |
| weak_en | output | 8 | Weak pull-up enables |
| med_en | output | 8 | Medium pull-up enables |
| strong_en | output | 8 | Strong pull-up pulse enables |

## Verification
The assertions assume that `wr_en`, `wr_data`, `weak_off` and `rd_rmw` are stable around each rising clock edge. They also assume that `pin_in` may change at any time but is only observed through the synchroniser. The stimulus changes every input on the falling edge only. Random phases mix sparse writes, biased pin patterns and rare `weak_off` pulses. Directed phases add back-to-back 0-to-1-to-0-to-1 writes, rewriting 1 over 1, and pins pulled low under a latch of 1.

// File: rtl/qb_port_ctrl.sv
module qb_port_ctrl #(
  parameter int W     = 8,
  parameter int PULSE = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_rmw,
  output logic [W-1:0] rd_data,
  input  logic         weak_off,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pd_en,
  output logic [W-1:0] weak_en,
  output logic [W-1:0] med_en,
  output logic [W-1:0] strong_en
);
  localparam int CW = $clog2(PULSE + 1);

  logic [W-1:0] latch_q, pin_s1, pin_s2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '1;
      pin_s1  <= '1;
      pin_s2  <= '1;
    end else begin
      if (wr_en) latch_q <= wr_data;
      pin_s1 <= pin_in;
      pin_s2 <= pin_s1;
    end
  end

  assign pd_en   = ~latch_q;
  assign weak_en = latch_q & {W{~weak_off}};
  assign med_en  = latch_q & pin_s2;
  assign rd_data = rd_rmw ? latch_q : pin_s2;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
      if (!rst_n)                                 cnt <= '0;
      else if (wr_en && wr_data[i] && !latch_q[i]) cnt <= CW'(PULSE);
      else if (wr_en && !wr_data[i])              cnt <= '0;
      else if (cnt != '0)                         cnt <= cnt - CW'(1);
    end

    assign strong_en[i] = (cnt != '0);

    AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_data[i] && pd_en[i] |=> strong_en[i]);  // R5
    AST_PULSE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      strong_en[i] && $past(strong_en[i]) |=> !strong_en[i]);  // R5
    AST_PULSE_KILL: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !wr_data[i] |=> !strong_en[i]);  // R6
    AST_NO_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      strong_en[i] |-> !pd_en[i]);  // R5
    AST_MED_NEEDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      med_en[i] |-> !pd_en[i]);  // R4
  end

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> pd_en == ~$past(wr_data));  // R1
  AST_WEAK_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    weak_off |-> weak_en == '0);  // R3
  AST_PIN_LOW_DROPS_MED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pin_in) == '0 && $past(pin_in, 2) == '0 |-> med_en == '0);  // R4
endmodule

// File: tb/qb_port_ctrl_tb.sv
module qb_port_ctrl_tb;
  localparam int W = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic wr_en = 0;
  logic [W-1:0] wr_data = '0;
  logic rd_rmw = 0;
  logic weak_off = 0;
  logic [W-1:0] pin_in = '1;
  logic [W-1:0] rd_data, pd_en, weak_en, med_en, strong_en;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [W-1:0] m_latch, m_s1, m_s2;
  int m_cnt [W];

  always #5 clk = ~clk;

  qb_port_ctrl #(.W(W), .PULSE(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_rmw(rd_rmw), .rd_data(rd_data), .weak_off(weak_off),
    .pin_in(pin_in), .pd_en(pd_en), .weak_en(weak_en),
    .med_en(med_en), .strong_en(strong_en)
  );

  function automatic logic [W-1:0] exp_strong();
    logic [W-1:0] s;
    for (int i = 0; i < W; i++) s[i] = (m_cnt[i] != 0);
    return s;
  endfunction

  function automatic logic [W-1:0] exp_rd(input logic rmw);
    return rmw ? m_latch : m_s2;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    for (int i = 0; i < W; i++) begin
      if (wr_en && wr_data[i] && !m_latch[i]) m_cnt[i] = 2;
      else if (wr_en && !wr_data[i])          m_cnt[i] = 0;
      else if (m_cnt[i] != 0)                 m_cnt[i] = m_cnt[i] - 1;
    end
    if (wr_en) m_latch = wr_data;
    m_s2 = m_s1;
    m_s1 = pin_in;
  endtask

  task automatic compare_all();
    chk("R1 pd_en", pd_en, ~m_latch);
    chk("R2/R3 weak_en", weak_en, m_latch & {W{~weak_off}});
    chk("R4 med_en", med_en, m_latch & m_s2);
    chk("R5 strong_en", strong_en, exp_strong());
    chk("R8 rd_data", rd_data, exp_rd(rd_rmw));
  endtask

  task automatic cyc(input logic w, input logic [W-1:0] d, input logic [W-1:0] p,
                     input logic off, input logic rmw);
    wr_en = w; wr_data = d; pin_in = p; weak_off = off; rd_rmw = rmw;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_latch = '1; m_s1 = '1; m_s2 = '1;
    for (int i = 0; i < W; i++) m_cnt[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R7: reset state
    chk("R7 pd_en after reset", pd_en, 8'h00);
    chk("R7 strong_en after reset", strong_en, 8'h00);
    rd_rmw = 1; #1;
    chk("R7 latch after reset", rd_data, 8'hFF);
    cyc(0, '0, '1, 0, 1);
    chk("R7 no pulse after reset", strong_en, 8'h00);

    // R1/R5: 0 then 1 gives a two-cycle pulse
    cyc(1, 8'h00, '1, 0, 1);
    chk("R1 pull-down on 0", pd_en, 8'hFF);
    cyc(1, 8'hFF, '1, 0, 1);
    chk("R5 pulse cycle 1", strong_en, 8'hFF);
    cyc(0, '0, '1, 0, 1);
    chk("R5 pulse cycle 2", strong_en, 8'hFF);
    cyc(0, '0, '1, 0, 1);
    chk("R5 pulse ended", strong_en, 8'h00);
    cyc(1, 8'hFF, '1, 0, 1);
    chk("R5 no pulse on 1 over 1", strong_en, 8'h00);

    // R6: kill and restart
    cyc(1, 8'h00, '1, 0, 1);
    cyc(1, 8'h0F, '1, 0, 1);
    chk("R9 pulse only on raised bits", strong_en, 8'h0F);
    cyc(1, 8'h00, '1, 0, 1);
    chk("R6 write 0 ends pulse", strong_en, 8'h00);
    cyc(1, 8'h0F, '1, 0, 1);
    chk("R6 restart cycle 1", strong_en, 8'h0F);
    cyc(1, 8'hF0, '1, 0, 1);
    chk("R9 independent bits", strong_en, 8'hF0);
    cyc(0, '0, '1, 0, 1);
    chk("R6 restart cycle 2", strong_en, 8'hF0);

    // R3: global weak off
    cyc(1, 8'hFF, '1, 1, 1);
    chk("R3 weak off", weak_en, 8'h00);
    cyc(0, '0, '1, 0, 1);
    chk("R2 weak on", weak_en, 8'hFF);

    // R4/R8: pin pulled low
    cyc(0, '0, 8'h3C, 0, 0);
    chk("R4 med after 1 edge", med_en, 8'hFF);
    cyc(0, '0, 8'h3C, 0, 0);
    chk("R4 med after 2 edges", med_en, 8'h3C);
    chk("R8 pin read", rd_data, 8'h3C);
    rd_rmw = 1; #1;
    chk("R8 rmw read", rd_data, 8'hFF);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic w, off, rmw;
      logic [W-1:0] d, p;
      w   = ($urandom % 3) == 0;
      d   = W'($urandom);
      p   = ($urandom % 2) ? W'($urandom) : m_latch;
      off = ($urandom % 8) == 0;
      rmw = $urandom % 2;
      cyc(w, d, p, off, rmw);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule